// File: doc/BRIEF.md
# Strobed Latched I/O Port

This block is an 8-bit parallel port that sits on a microprocessor bus. A bank of transparent data latches captures the input byte. A mode pin picks how the port behaves. In output-port mode the driver is always on, and the bank is opened by the device-select term. In input-port mode the bank is opened by an external strobe, and the driver is turned on only while the device is selected. The driver enable is brought out on its own pin so that a pad ring can tri-state the data lines when it is low.

A service-request flag is set when the strobe falls. It produces an active-low interrupt towards the processor. Selecting the device both clears the flag and masks the interrupt, so reading the port acknowledges the request.

Every pin is asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the level-sensitive and edge-sensitive behaviour is then modelled on that single clock. A synchronous active-high reset empties the latches and clears the request.

Top module: `strobed_io_port`

## Requirements
- R1: The device counts as selected only while `sel_a_n` is 0 and `sel_b` is 1; the other three combinations of those two pins leave it unselected.
- R2: With `mode` = 1, `dout_oe` is 1 whatever the select pins are, and the latch is open exactly while the device is selected.
- R3: With `mode` = 0, `dout_oe` equals the select term, and the latch is open exactly while `strobe` is 1.
- R4: While the latch is open, `dout` follows `din`. Once the latch closes, `dout` keeps the last byte taken.
- R5: `clear_n` = 0 while the latch is closed drives `dout` to 8'h00.
- R6: `clear_n` = 0 while the latch is open has no effect: `dout` keeps following `din`.
- R7: A 1-to-0 transition of `strobe` sets the service request, which drives `irq_n` to 0 while the device is not selected.
- R8: Selecting the device clears the service request and holds `irq_n` at 1. After deselection `irq_n` stays 1 until the next strobe fall.
- R9: `clear_n` = 0 clears the service request, so `irq_n` returns to 1. When a clear and a strobe fall arrive together, the clear wins.
- R10: While `rst` is 1, `dout` is 8'h00, `irq_n` is 1 and `dout_oe` is 0. The port comes out of reset as unselected in input-port mode with no pending request.
- R11: A change on `din` while the latch is open appears on `dout` after the third rising clock edge: two synchronizer stages and then the latch register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Data byte into the latch bank |
| sel_a_n | input | 1 | Active-low device select |
| sel_b | input | 1 | Active-high device select |
| mode | input | 1 | 1 = output-port mode, 0 = input-port (strobed) mode |
| strobe | input | 1 | Latch clock in input-port mode; its falling edge raises a service request |
| clear_n | input | 1 | Active-low clear of the latch (when closed) and of the request |
| dout | output | 8 | Latch contents |
| dout_oe | output | 1 | Driver enable for the data pads; low means tri-state |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions take for granted that the pins are sampled through the synchronizers. They reason only about the synchronized copies, and they expect every pin to be held stable long enough for a change to pass through both stages, so that a pulse cannot be lost between samples. The stimulus changes all pins together on the falling clock edge and then holds them for four clock cycles. As a result every strobe level, select pulse and clear pulse is seen by the synchronizers. Constrained random pin combinations are mixed with directed sequences: a clear during transparency, a clear after latching, a strobe followed by select acknowledge, and a simultaneous clear and strobe fall.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Bit positions inside the synchronized control vector
    localparam int CTRL_W   = 5;
    localparam int CI_SELN  = 0;
    localparam int CI_SEL   = 1;
    localparam int CI_MODE  = 2;
    localparam int CI_STB   = 3;
    localparam int CI_CLRN  = 4;

    // Idle levels loaded on reset: unselected, input-port mode, no clear
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b1_0_0_0_1;

    typedef struct packed {
        logic stb_prev;
        logic req;
    } req_state_t;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/sio_latch_bank.sv
module sio_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open_en,
    input  logic         clr_hit,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] lat_d, lat_q;

    // Each bit: open latch follows data (overrides clear); closed latch
    // either clears or holds.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign lat_d[g] = open_en ? din[g]
                        : (clr_hit ? 1'b0 : lat_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign q = lat_q;

endmodule

// File: rtl/sio_service_req.sv
module sio_service_req
    import sio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_s,
    input  logic clear_hit,
    output logic req,
    output logic fall
);

    req_state_t rs_d, rs_q;

    always_comb begin
        rs_d          = rs_q;
        rs_d.stb_prev = strobe_s;
        fall          = rs_q.stb_prev & ~strobe_s;
        if (clear_hit) begin
            rs_d.req = 1'b0;
        end else if (fall) begin
            rs_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '{stb_prev: 1'b0, req: 1'b0};
        end else begin
            rs_q <= rs_d;
        end
    end

    assign req = rs_q.req;

endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              mode,
    input  logic              strobe,
    input  logic              clear_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              irq_n
);

    logic [DATA_W-1:0] din_s;
    logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
    logic              sel_act, mode_s, stb_s, clr_n_s;
    logic              eff_clk, req_clear, req_q, stb_fall;
    logic [DATA_W-1:0] latch_q;

    assign ctrl_raw[CI_SELN] = sel_a_n;
    assign ctrl_raw[CI_SEL]  = sel_b;
    assign ctrl_raw[CI_MODE] = mode;
    assign ctrl_raw[CI_STB]  = strobe;
    assign ctrl_raw[CI_CLRN] = clear_n;

    sio_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk      (clk),
        .rst      (rst),
        .async_in (din),
        .sync_out (din_s)
    );

    sio_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk      (clk),
        .rst      (rst),
        .async_in (ctrl_raw),
        .sync_out (ctrl_s)
    );

    // Decode and mode steering
    always_comb begin
        sel_act   = ~ctrl_s[CI_SELN] & ctrl_s[CI_SEL];
        mode_s    = ctrl_s[CI_MODE];
        stb_s     = ctrl_s[CI_STB];
        clr_n_s   = ctrl_s[CI_CLRN];
        eff_clk   = mode_s ? sel_act : stb_s;
        dout_oe   = mode_s ? 1'b1 : sel_act;
        req_clear = sel_act | ~clr_n_s;
    end

    sio_latch_bank #(.W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .open_en (eff_clk),
        .clr_hit (~clr_n_s),
        .din     (din_s),
        .q       (latch_q)
    );

    sio_service_req u_req (
        .clk       (clk),
        .rst       (rst),
        .strobe_s  (stb_s),
        .clear_hit (req_clear),
        .req       (req_q),
        .fall      (stb_fall)
    );

    assign dout  = latch_q;
    assign irq_n = ~(req_q & ~sel_act);

endmodule

// File: rtl/sio_port_checker.sv
module sio_port_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] din_s,
    input logic         sel_act,
    input logic         mode_s,
    input logic         eff_clk,
    input logic         clr_n_s,
    input logic         stb_fall,
    input logic [W-1:0] latch_q,
    input logic         req_q,
    input logic         dout_oe,
    input logic         irq_n
);

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        eff_clk |=> latch_q == $past(din_s));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!eff_clk && clr_n_s) |=> $stable(latch_q));

    assert_clear_closed_R5: assert property (@(posedge clk) disable iff (rst)
        (!eff_clk && !clr_n_s) |=> latch_q == '0);

    assert_clear_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (eff_clk && !clr_n_s) |=> latch_q == $past(din_s));

    assert_req_set_R7: assert property (@(posedge clk) disable iff (rst)
        (stb_fall && !sel_act && clr_n_s) |=> req_q);

    assert_sel_masks_R8: assert property (@(posedge clk) disable iff (rst)
        sel_act |-> irq_n);

    assert_sel_clears_R8: assert property (@(posedge clk) disable iff (rst)
        sel_act |=> !req_q);

    assert_req_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> !req_q);

    assert_oe_mode_R2: assert property (@(posedge clk) disable iff (rst)
        mode_s |-> dout_oe);

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && !req_q && irq_n));

endmodule

bind strobed_io_port sio_port_checker #(.W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .din_s    (din_s),
    .sel_act  (sel_act),
    .mode_s   (mode_s),
    .eff_clk  (eff_clk),
    .clr_n_s  (clr_n_s),
    .stb_fall (stb_fall),
    .latch_q  (latch_q),
    .req_q    (req_q),
    .dout_oe  (dout_oe),
    .irq_n    (irq_n)
);

// File: tb/strobed_io_port_tb.sv
module strobed_io_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic       sel_a_n, sel_b, mode, strobe, clear_n;
    logic [7:0] dout;
    logic       dout_oe, irq_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Reference model state
    logic [7:0] m_lat;
    logic       m_req, m_stb;

    always #10 clk = ~clk;

    strobed_io_port dut_i (
        .clk(clk), .rst(rst), .din(din), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .mode(mode), .strobe(strobe), .clear_n(clear_n),
        .dout(dout), .dout_oe(dout_oe), .irq_n(irq_n)
    );

    function automatic logic f_sel(input logic sn, input logic s);
        return !sn && s;
    endfunction

    function automatic logic f_oe(input logic md, input logic sl);
        return md ? 1'b1 : sl;
    endfunction

    function automatic logic f_open(input logic md, input logic sl, input logic st);
        return md ? sl : st;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic sl;
        sl = f_sel(sel_a_n, sel_b);
        chk(dout == m_lat, tag, "dout", dout, m_lat);
        chk(dout_oe == f_oe(mode, sl), tag, "dout_oe", dout_oe, f_oe(mode, sl));
        chk(irq_n == !(m_req && !sl), tag, "irq_n", irq_n, !(m_req && !sl));
    endtask

    // Apply one pin combination, advance the model, wait for settling, check
    task automatic step(input logic sn, input logic s, input logic md,
                        input logic st, input logic cn, input logic [7:0] d,
                        input string tag);
        logic sl, fall;
        sel_a_n = sn; sel_b = s; mode = md; strobe = st; clear_n = cn; din = d;
        sl   = f_sel(sn, s);
        fall = m_stb && !st;
        if (f_open(md, sl, st)) m_lat = d;
        else if (!cn)           m_lat = 8'h00;
        if (sl || !cn)          m_req = 1'b0;
        else if (fall)          m_req = 1'b1;
        m_stb = st;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sel_a_n = 1'b1; sel_b = 1'b0; mode = 1'b0; strobe = 1'b0;
        clear_n = 1'b1; din = 8'h00;
        m_lat = 8'h00; m_req = 1'b0; m_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout == 8'h00, "R10", "dout in reset", dout, 0);
        chk(irq_n == 1'b1, "R10", "irq_n in reset", irq_n, 1);
        chk(dout_oe == 1'b0, "R10", "dout_oe in reset", dout_oe, 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        @(negedge clk);
        do_reset();

        // R3 / R4: strobed mode, open then close
        step(1, 0, 0, 1, 1, 8'hA5, "R3 strobe open, R4 follow");
        step(1, 0, 0, 0, 1, 8'h3C, "R4 hold after close, R7 strobe fall");
        chk(irq_n == 1'b0, "R7", "irq_n after strobe fall", irq_n, 0);
        chk(dout == 8'hA5, "R4", "held byte", dout, 8'hA5);
        // R8: select acknowledges
        step(0, 1, 0, 0, 1, 8'h3C, "R8 select acknowledges");
        chk(dout_oe == 1'b1, "R1", "selected oe in mode 0", dout_oe, 1);
        step(1, 0, 0, 0, 1, 8'h3C, "R8 stays released");
        chk(irq_n == 1'b1, "R8", "irq_n after deselect", irq_n, 1);
        // R1: partial selects
        step(1, 1, 0, 0, 1, 8'h11, "R1 sel_a_n high");
        chk(dout_oe == 1'b0, "R1", "oe with sel_a_n high", dout_oe, 0);
        step(0, 0, 0, 0, 1, 8'h22, "R1 sel_b low");
        chk(dout_oe == 1'b0, "R1", "oe with sel_b low", dout_oe, 0);
        // R2: output-port mode
        step(1, 0, 1, 0, 1, 8'h66, "R2 unselected oe on, latch closed");
        chk(dout == 8'hA5, "R2", "closed without select", dout, 8'hA5);
        step(0, 1, 1, 0, 1, 8'h5A, "R2 select opens latch");
        chk(dout == 8'h5A, "R2", "opened by select", dout, 8'h5A);
        // R6: clear while open
        step(0, 1, 1, 0, 0, 8'h77, "R6 clear while open");
        chk(dout == 8'h77, "R6", "clear ignored", dout, 8'h77);
        // R5: deselect while clear held -> closed and cleared
        step(1, 0, 1, 0, 0, 8'h88, "R5 clear while closed");
        chk(dout == 8'h00, "R5", "cleared", dout, 0);
        // R9: strobe fall then clear
        step(1, 0, 0, 1, 1, 8'h99, "R4 strobe open");
        step(1, 0, 0, 0, 1, 8'h99, "R7 fall");
        chk(irq_n == 1'b0, "R7", "request pending", irq_n, 0);
        step(1, 0, 0, 0, 0, 8'h99, "R9 clear drops request");
        chk(irq_n == 1'b1, "R9", "request cleared", irq_n, 1);
        chk(dout == 8'h00, "R5", "latch cleared by clear", dout, 0);
        // R9: simultaneous clear and strobe fall
        step(1, 0, 0, 1, 1, 8'h42, "R4 strobe open");
        step(1, 0, 0, 0, 0, 8'h42, "R9 clear beats fall");
        chk(irq_n == 1'b1, "R9", "clear wins", irq_n, 1);

        // R11: exact latency with latch open
        step(0, 1, 1, 0, 1, 8'h11, "R11 setup");
        din = 8'h22;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(dout == 8'h11, "R11", "unchanged after two edges", dout, 8'h11);
        @(posedge clk);
        @(negedge clk);
        chk(dout == 8'h22, "R11", "changed after third edge", dout, 8'h22);
        m_lat = 8'h22;

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            logic sn, s, md, st, cn;
            d  = 8'($urandom);
            sn = 1'($urandom);
            s  = 1'($urandom);
            md = ($urandom % 3) == 0;
            st = 1'($urandom);
            cn = ($urandom % 4) != 0;
            step(sn, s, md, st, cn, d, "random");
        end

        // R10: reset in mid-operation
        step(1, 0, 0, 1, 1, 8'hEE, "R4 before reset");
        step(1, 0, 0, 0, 1, 8'hEE, "R7 pending before reset");
        do_reset();
        check_all("R10 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule